// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs one read or one write cycle at a time to external memory or I/O devices that share a single set of pins for address and data. A requester presents an address, write data, a direction bit, a memory-space select and a timing-profile select. When the block is idle and sees a valid request, it sequences the pins through these phases: address setup, address strobe low, address hold, bus turnaround, data strobe low and recovery. During the recovery phase it pulses a done flag. For a read, the data captured at the end of the strobe is left on the response port.

Each phase has a length in clocks set by a parameter. The extended profile multiplies every phase length by a common factor. In the last clock of the data-strobe phase the block samples a low-active wait input. Each low sample adds one clock to the strobe. Read data is captured only in the clock in which wait is seen high, and that clock is the one that ends with the data strobe rising.

Top module: `mxbus_ctrl`

## Requirements
- R1: Out of reset and between cycles the pins are idle: as_n=1, ds_n=1, rw_n=1 (read), dm_n=1, bus_oe=0, req_ready=1 and rsp_done=0.
- R2: A request with req_valid=1 while req_ready=1 starts a cycle in the next clock, and req_ready drops for the whole cycle. req_valid seen while req_ready=0 is ignored and starts nothing.
- R3: The address drives bus_out with bus_oe=1 for ASU_CLK clocks with as_n high. as_n is then low for ASW_CLK clocks while the address stays driven.
- R4: After as_n rises, the address stays driven for AHD_CLK clocks with both strobes high. as_n and ds_n are never low together.
- R5: On a read, bus_oe is 0 for TRN_CLK clocks before ds_n falls and stays 0 until the cycle ends. ds_n is low for RDS_CLK clocks. rsp_rdata takes the value of bus_in from the last ds_n-low clock and holds it afterwards.
- R6: On a write, req_wdata drives the bus from TRN_CLK clocks before ds_n falls through the end of recovery. ds_n is low for WDS_CLK clocks, which is fewer than on a read.
- R7: rw_n (1=read, 0=write) and dm_n (0 when req_dmem=1) are valid from the first setup clock through the last recovery clock and do not change within a cycle.
- R8: With ext_mode=1 sampled at acceptance, every phase length is multiplied by EXT_MUL (default 2).
- R9: wait_n is sampled only in the last ds_n-low clock. Each low sample there lengthens the strobe by one clock. Low values at any other time have no effect.
- R10: ds_n stays high for REC_CLK clocks of recovery. rsp_done is 1 only in the last recovery clock, and the next clock is idle and can accept a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Extended timing select, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this clock if valid |
| req_addr | input | BUS_W | Address for the cycle |
| req_wdata | input | BUS_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dmem | input | 1 | Selects data-memory space |
| rsp_rdata | output | BUS_W | Last read data captured |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| as_n | output | 1 | Address strobe, low active |
| ds_n | output | 1 | Data strobe, low active |
| rw_n | output | 1 | High for read, low for write |
| dm_n | output | 1 | Data-memory select, low active |
| bus_out | output | BUS_W | Shared bus output value |
| bus_oe | output | 1 | Shared bus output enable |
| bus_in | input | BUS_W | Shared bus input value |
| wait_n | input | 1 | Wait request, low active |

## Verification
The bench keeps wait_n low outside the sampling clock. A design that samples wait in any other clock would therefore hang or stretch the wrong phase. During the strobe, bus_in carries a decoy value that changes to the real data only in the final clock, so capturing one clock early returns the wrong read data. A request is held valid while the block is busy, which exposes a design that restarts a cycle. Extended-mode cycles with waits check that the multiplier applies to every phase and not only to the strobes. Back-to-back requests check that recovery is kept and that the block accepts in the clock after done.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ASLOW = 3'd2,
    PH_AHOLD = 3'd3,
    PH_TURN  = 3'd4,
    PH_STRB  = 3'd5,
    PH_RECOV = 3'd6
  } phase_e;
endpackage

// File: rtl/mxbus_rstsync.sv
module mxbus_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/mxbus_len.sv
module mxbus_len
  import mxbus_pkg::*;
#(
  parameter int ASU_CLK = 1,
  parameter int ASW_CLK = 1,
  parameter int AHD_CLK = 1,
  parameter int TRN_CLK = 1,
  parameter int RDS_CLK = 3,
  parameter int WDS_CLK = 2,
  parameter int REC_CLK = 1,
  parameter int EXT_MUL = 2,
  parameter int CNT_W   = 5
) (
  input  phase_e           phase,
  input  logic             is_write,
  input  logic             is_ext,
  output logic [CNT_W-1:0] len_m1
);
  int base;
  int total;

  always_comb begin
    case (phase)
      PH_SETUP: base = ASU_CLK;
      PH_ASLOW: base = ASW_CLK;
      PH_AHOLD: base = AHD_CLK;
      PH_TURN:  base = TRN_CLK;
      PH_STRB:  base = is_write ? WDS_CLK : RDS_CLK;
      PH_RECOV: base = REC_CLK;
      default:  base = 1;
    endcase
    total  = is_ext ? base * EXT_MUL : base;
    len_m1 = CNT_W'(total - 1);
  end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int ASU_CLK = 1,
  parameter int ASW_CLK = 1,
  parameter int AHD_CLK = 1,
  parameter int TRN_CLK = 1,
  parameter int RDS_CLK = 3,
  parameter int WDS_CLK = 2,
  parameter int REC_CLK = 1,
  parameter int EXT_MUL = 2,
  parameter int CNT_W   = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   new_write,
  input  logic   new_ext,
  input  logic   cur_write,
  input  logic   cur_ext,
  input  logic   wait_n,
  output phase_e phase,
  output logic   capture,
  output logic   done
);
  phase_e           ph_q, ph_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CNT_W-1:0] len_m1;
  logic             load;
  logic             cnt_zero;
  logic             sel_write, sel_ext;

  assign cnt_zero  = (cnt_q == '0);
  assign sel_write = (ph_q == PH_IDLE) ? new_write : cur_write;
  assign sel_ext   = (ph_q == PH_IDLE) ? new_ext   : cur_ext;

  mxbus_len #(
    .ASU_CLK(ASU_CLK), .ASW_CLK(ASW_CLK), .AHD_CLK(AHD_CLK),
    .TRN_CLK(TRN_CLK), .RDS_CLK(RDS_CLK), .WDS_CLK(WDS_CLK),
    .REC_CLK(REC_CLK), .EXT_MUL(EXT_MUL), .CNT_W(CNT_W)
  ) u_len (
    .phase    (ph_nx),
    .is_write (sel_write),
    .is_ext   (sel_ext),
    .len_m1   (len_m1)
  );

  // next-state process
  always_comb begin
    ph_nx = ph_q;
    load  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_nx = PH_SETUP;
          load  = 1'b1;
        end
      end
      PH_STRB: begin
        if (cnt_zero && wait_n) begin
          ph_nx = PH_RECOV;
          load  = 1'b1;
        end
      end
      default: begin
        if (cnt_zero) begin
          load = 1'b1;
          case (ph_q)
            PH_SETUP: ph_nx = PH_ASLOW;
            PH_ASLOW: ph_nx = PH_AHOLD;
            PH_AHOLD: ph_nx = PH_TURN;
            PH_TURN:  ph_nx = PH_STRB;
            default:  ph_nx = PH_IDLE;
          endcase
        end
      end
    endcase

    if (load) begin
      cnt_nx = (ph_nx == PH_IDLE) ? '0 : len_m1;
    end else if (!cnt_zero) begin
      cnt_nx = cnt_q - 1'b1;
    end else begin
      cnt_nx = cnt_q;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign phase   = ph_q;
  assign capture = (ph_q == PH_STRB) && cnt_zero && wait_n;
  assign done    = (ph_q == PH_RECOV) && cnt_zero;
endmodule

// File: rtl/mxbus_dpath.sv
module mxbus_dpath
  import mxbus_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic             req_write,
  input  logic             req_dmem,
  input  logic             ext_mode,
  input  phase_e           phase,
  input  logic             capture,
  input  logic [BUS_W-1:0] bus_in,
  output logic             cur_write,
  output logic             cur_ext,
  output logic [BUS_W-1:0] rdata,
  output logic             as_n,
  output logic             ds_n,
  output logic             rw_n,
  output logic             dm_n,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe
);
  logic [BUS_W-1:0] addr_q, wdata_q, rdata_q;
  logic             write_q, dmem_q, ext_q;
  logic [BUS_W-1:0] addr_nx, wdata_nx, rdata_nx;
  logic             write_nx, dmem_nx, ext_nx;
  logic             addr_ph, data_ph, in_txn;

  // next-state process with explicit enables
  always_comb begin
    addr_nx  = addr_q;
    wdata_nx = wdata_q;
    write_nx = write_q;
    dmem_nx  = dmem_q;
    ext_nx   = ext_q;
    rdata_nx = rdata_q;
    if (start) begin
      addr_nx  = req_addr;
      wdata_nx = req_wdata;
      write_nx = req_write;
      dmem_nx  = req_dmem;
      ext_nx   = ext_mode;
    end
    if (capture && !write_q) begin
      rdata_nx = bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      dmem_q  <= 1'b0;
      ext_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_nx;
      wdata_q <= wdata_nx;
      write_q <= write_nx;
      dmem_q  <= dmem_nx;
      ext_q   <= ext_nx;
      rdata_q <= rdata_nx;
    end
  end

  // pin decode from the current phase
  always_comb begin
    addr_ph = (phase == PH_SETUP) || (phase == PH_ASLOW) || (phase == PH_AHOLD);
    data_ph = (phase == PH_TURN)  || (phase == PH_STRB)  || (phase == PH_RECOV);
    in_txn  = (phase != PH_IDLE);
    as_n    = (phase != PH_ASLOW);
    ds_n    = (phase != PH_STRB);
    rw_n    = in_txn ? !write_q : 1'b1;
    dm_n    = in_txn ? !dmem_q  : 1'b1;
    bus_oe  = addr_ph || (data_ph && write_q);
    if (addr_ph) begin
      bus_out = addr_q;
    end else if (data_ph && write_q) begin
      bus_out = wdata_q;
    end else begin
      bus_out = '0;
    end
  end

  assign cur_write = write_q;
  assign cur_ext   = ext_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxbus_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int ASU_CLK = 1,
  parameter int ASW_CLK = 1,
  parameter int AHD_CLK = 1,
  parameter int TRN_CLK = 1,
  parameter int RDS_CLK = 3,
  parameter int WDS_CLK = 2,
  parameter int REC_CLK = 1,
  parameter int EXT_MUL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic             req_write,
  input  logic             req_dmem,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic             rsp_done,
  output logic             as_n,
  output logic             ds_n,
  output logic             rw_n,
  output logic             dm_n,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             wait_n
);
  localparam int LONGEST = (ASU_CLK + ASW_CLK + AHD_CLK + TRN_CLK + RDS_CLK
                            + WDS_CLK + REC_CLK) * EXT_MUL;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic   rst_sync_n;
  phase_e phase;
  logic   capture, done, start;
  logic   cur_write, cur_ext;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign rsp_done  = done;

  mxbus_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mxbus_seq #(
    .ASU_CLK(ASU_CLK), .ASW_CLK(ASW_CLK), .AHD_CLK(AHD_CLK),
    .TRN_CLK(TRN_CLK), .RDS_CLK(RDS_CLK), .WDS_CLK(WDS_CLK),
    .REC_CLK(REC_CLK), .EXT_MUL(EXT_MUL), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .new_write (req_write),
    .new_ext   (ext_mode),
    .cur_write (cur_write),
    .cur_ext   (cur_ext),
    .wait_n    (wait_n),
    .phase     (phase),
    .capture   (capture),
    .done      (done)
  );

  mxbus_dpath #(.BUS_W(BUS_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_write (req_write),
    .req_dmem  (req_dmem),
    .ext_mode  (ext_mode),
    .phase     (phase),
    .capture   (capture),
    .bus_in    (bus_in),
    .cur_write (cur_write),
    .cur_ext   (cur_ext),
    .rdata     (rsp_rdata),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .rw_n      (rw_n),
    .dm_n      (dm_n),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe)
  );
endmodule

// File: rtl/mxbus_chk.sv
module mxbus_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_done,
  input logic             as_n,
  input logic             ds_n,
  input logic             rw_n,
  input logic             dm_n,
  input logic [BUS_W-1:0] bus_out,
  input logic             bus_oe
);
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (as_n && ds_n && rw_n && dm_n && !bus_oe && !rsp_done));

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!as_n && !ds_n));

  a_r4_addr_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_n) |-> (bus_oe && $stable(bus_out)));

  a_r5_float_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ds_n) && rw_n) |-> (!bus_oe && !$past(bus_oe)));

  a_r6_wdata_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ds_n) && !rw_n) |-> (bus_oe && $past(bus_oe) && $stable(bus_out)));

  a_r7_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(rw_n) && $stable(dm_n)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (req_ready && !rsp_done));
endmodule

bind mxbus_ctrl mxbus_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .as_n      (as_n),
  .ds_n      (ds_n),
  .rw_n      (rw_n),
  .dm_n      (dm_n),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe)
);

// File: tb/mxbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module mxbus_ctrl_tb_top;
  localparam int BW = 8;

  logic          clk;
  logic          rst_n;
  logic          ext_mode, req_valid, req_ready, req_write, req_dmem;
  logic [BW-1:0] req_addr, req_wdata, rsp_rdata, bus_out, bus_in;
  logic          rsp_done, as_n, ds_n, rw_n, dm_n, bus_oe, wait_n;

  int checks = 0;
  int errors = 0;

  mxbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_dmem(req_dmem), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dm_n(dm_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .wait_n(wait_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {ready, done, as_n, ds_n, oe} and {rw_n, dm_n}, bus separately
  task automatic cmp_cycle(input logic [4:0] ctl_e, input logic [1:0] dir_e,
                           input logic [BW-1:0] bus_e, input string tag);
    logic [4:0] ctl_a;
    ctl_a = {req_ready, rsp_done, as_n, ds_n, bus_oe};
    checks++;
    if (ctl_a !== ctl_e) begin
      errors++;
      $display("FAIL %s ctl{rdy,done,as,ds,oe} actual=%b expected=%b t=%0t", tag, ctl_a, ctl_e, $time);
    end
    checks++;
    if ({rw_n, dm_n} !== dir_e) begin
      errors++;
      $display("FAIL R7 (%s) {rw_n,dm_n} actual=%b expected=%b t=%0t", tag, {rw_n, dm_n}, dir_e, $time);
    end
    if (ctl_e[0]) begin
      checks++;
      if (bus_out !== bus_e) begin
        errors++;
        $display("FAIL %s bus_out actual=%h expected=%h t=%0t", tag, bus_out, bus_e, $time);
      end
    end
  endtask

  task automatic check_idle(input string tag);
    cmp_cycle(5'b10110, 2'b11, '0, tag);
  endtask

  // One cycle of the bus, modelled as a list of expected clocks.
  task automatic run_txn(input bit wr, input bit dmem, input bit ext,
                         input logic [BW-1:0] addr, input logic [BW-1:0] wd,
                         input int nwait, input logic [BW-1:0] rd_in,
                         input bit poke_busy);
    int m, base_s;
    logic [4:0]    ctl_q[$];
    logic [BW-1:0] bus_q[$];
    string         tag_q[$];
    int            strb_q[$];
    logic [1:0]    dir;
    string         pre;
    m      = ext ? 2 : 1;
    base_s = (wr ? 2 : 3) * m;
    dir    = {~wr, ~dmem};
    pre    = ext ? "R8 " : "";
    for (int i = 0; i < m; i++) begin ctl_q.push_back(5'b00111); bus_q.push_back(addr); tag_q.push_back({pre, "R3"}); strb_q.push_back(-1); end
    for (int i = 0; i < m; i++) begin ctl_q.push_back(5'b00011); bus_q.push_back(addr); tag_q.push_back({pre, "R3"}); strb_q.push_back(-1); end
    for (int i = 0; i < m; i++) begin ctl_q.push_back(5'b00111); bus_q.push_back(addr); tag_q.push_back({pre, "R4"}); strb_q.push_back(-1); end
    for (int i = 0; i < m; i++) begin ctl_q.push_back({4'b0011, wr}); bus_q.push_back(wd); tag_q.push_back({pre, wr ? "R6" : "R5"}); strb_q.push_back(-1); end
    for (int k = 0; k < base_s + nwait; k++) begin
      ctl_q.push_back({4'b0010, wr}); bus_q.push_back(wd);
      tag_q.push_back({pre, nwait > 0 ? "R9" : (wr ? "R6" : "R5")}); strb_q.push_back(k);
    end
    for (int i = 0; i < m; i++) begin
      ctl_q.push_back({1'b0, i == m - 1, 2'b11, wr}); bus_q.push_back(wd);
      tag_q.push_back({pre, "R10"}); strb_q.push_back(-1);
    end

    @(negedge clk);
    check_idle({pre, "R1"});
    req_valid = 1'b1; req_write = wr; req_dmem = dmem; ext_mode = ext;
    req_addr = addr; req_wdata = wd;
    for (int idx = 0; idx < ctl_q.size(); idx++) begin
      int k;
      @(negedge clk);
      cmp_cycle(ctl_q[idx], dir, bus_q[idx], tag_q[idx]);
      k = strb_q[idx];
      // wait_n low everywhere except the sampling clock that ends the strobe
      wait_n = (k == base_s - 1 + nwait);
      bus_in = (k == base_s - 1 + nwait) ? rd_in : ~rd_in;
      if (poke_busy && idx < ctl_q.size() - 1) begin
        req_valid = 1'b1; req_addr = ~addr; req_write = ~wr; ext_mode = ~ext;
      end else begin
        req_valid = 1'b0;
      end
    end
    if (!wr) begin
      @(negedge clk);
      check_idle({pre, "R10"});
      checks++;
      if (rsp_rdata !== rd_in) begin
        errors++;
        $display("FAIL R5 rsp_rdata actual=%h expected=%h", rsp_rdata, rd_in);
      end
    end
    wait_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_mode = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_wdata = '0; req_write = 1'b0; req_dmem = 1'b0; bus_in = '0; wait_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after release");

    run_txn(0, 0, 0, 8'h3C, 8'h00, 0, 8'hA5, 0);  // R5 plain read
    run_txn(1, 1, 0, 8'h81, 8'h5E, 0, 8'h00, 0);  // R6 write, R7 data space
    run_txn(0, 1, 1, 8'hF0, 8'h00, 0, 8'h69, 0);  // R8 extended read
    run_txn(1, 0, 1, 8'h12, 8'hC3, 0, 8'h00, 0);  // R8 extended write
    run_txn(0, 0, 0, 8'h44, 8'h00, 2, 8'h96, 0);  // R9 two waits on a read
    run_txn(1, 1, 0, 8'h07, 8'h7E, 1, 8'h00, 0);  // R9 one wait on a write
    run_txn(0, 0, 0, 8'h55, 8'h00, 0, 8'h1B, 1);  // R2 request held while busy
    repeat (2) begin
      @(negedge clk);
      check_idle("R2 busy request ignored");
    end
    run_txn(0, 1, 1, 8'hAA, 8'h00, 3, 8'hE7, 0);  // R8 R9 extended with waits
    run_txn(1, 0, 0, 8'h99, 8'h24, 0, 8'h00, 0);  // R10 back-to-back after done
    run_txn(0, 0, 0, 8'h66, 8'h00, 0, 8'h00, 0);  // R10 back-to-back read of zero

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule